// File: doc/BRIEF.md
# Two-Port Shared Memory with Selectable Read Latency

This block holds a shared storage array that two independent ports reach in the same clock cycle. Each port has a 72-bit data path, a write strobe, an address and two enable inputs. A port performs an access only in a cycle where both of its enables are high. A write lands in the array at the clock edge that samples it. A read returns the addressed word after a latency that each port chooses for itself while it is held in reset.

Each port's latency choice is a two-state machine. State `ST_FLOW` delivers read data one clock after the address edge. State `ST_PIPE` passes the data through a second register and delivers it two clocks after. Transition "reset-select": while `rst` is high, the state is loaded from the port's `*_pipe_sel` input (high selects `ST_PIPE`, low selects `ST_FLOW`). Transition "hold": once `rst` is low, the state keeps its value and the select input has no effect. The read data bus is driven only when the enable condition of a read, delayed by the chosen latency, is true. Otherwise the bus is forced to zero and the valid flag is low.

When both ports write one address in the same cycle, port A's word is kept. A read that meets a write to the same address from the other port in the same cycle returns the word held before that write.

Top module: `dpm_dual_top`

## Requirements
- R1: Port A and port B access the array in the same cycle without interfering; a word written through one port is read back unchanged through the other.
- R2: A write takes effect only when `*_en0` and `*_en1` are both 1 in the sampled cycle; with either enable at 0 the array word is left unchanged.
- R3: In `ST_FLOW` (selected by `*_pipe_sel`=0 during reset), a read sampled at edge T shows its data and `*_rvalid`=1 in the cycle right after T.
- R4: In `ST_PIPE` (selected by `*_pipe_sel`=1 during reset), a read sampled at edge T shows `*_rvalid`=0 in the cycle after T and its data with `*_rvalid`=1 in the cycle after T+1; reads issued on consecutive cycles come out on consecutive cycles.
- R5: `*_rvalid` is 1 exactly when, one latency earlier, the port sampled a read (both enables 1, `*_wr`=0); a write or a cycle with an enable at 0 produces `*_rvalid`=0.
- R6: Whenever `*_rvalid` is 0, `*_rdata` is all zeros, including during and just after reset.
- R7: A write committed at one edge is returned by a read of the same address on the same port sampled at the next edge.
- R8: A port's latency is taken from `*_pipe_sel` only while `rst`=1; changes of `*_pipe_sel` after reset leave the latency unchanged.
- R9: If both ports write the same address in one cycle, port A's word is stored; a read meeting the other port's write to its address in the same cycle returns the earlier word.
- R10: The two ports choose their latencies independently; one port can run in `ST_PIPE` while the other runs in `ST_FLOW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset; also the window in which the latency is chosen |
| a_pipe_sel | input | 1 | Port A latency select, sampled during reset (1 = two stages) |
| a_en0 | input | 1 | Port A first enable |
| a_en1 | input | 1 | Port A second enable |
| a_wr | input | 1 | Port A write strobe (1 = write, 0 = read) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when not valid |
| a_rvalid | output | 1 | Port A read data valid |
| b_pipe_sel | input | 1 | Port B latency select, sampled during reset (1 = two stages) |
| b_en0 | input | 1 | Port B first enable |
| b_en1 | input | 1 | Port B second enable |
| b_wr | input | 1 | Port B write strobe (1 = write, 0 = read) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when not valid |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
The assertions check every cycle that each port's valid flag follows its own read-enable history. They use the latency the checker captured during reset: one cycle back in `ST_FLOW` and two in `ST_PIPE`. They also check that the data bus is zero whenever valid is low. The data content is shown only by the bench scenarios. These cover cross-port transfer, gated writes that leave a word intact, write-then-read on the next edge, same-address write collisions with port A's priority and old-data reads, mixed latencies, and a select input that changes after reset and has no effect.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    localparam int NUM_PORTS = 2;

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_PIPE = 1'b1
    } lat_state_e;

endpackage

// File: rtl/dpm_shared_array.sv
module dpm_shared_array #(
    parameter int DATA_W = 72,
    parameter int ADDR_W = 6
) (
    input  logic                                           clk,
    input  logic [dpm_pkg::NUM_PORTS-1:0]                  wr_en,
    input  logic [dpm_pkg::NUM_PORTS-1:0][ADDR_W-1:0]      addr,
    input  logic [dpm_pkg::NUM_PORTS-1:0][DATA_W-1:0]      wdata,
    output logic [dpm_pkg::NUM_PORTS-1:0][DATA_W-1:0]      rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Port B is written first so that port A overrides it on a shared address (R9).
    always_ff @(posedge clk) begin
        if (wr_en[1]) store[addr[1]] <= wdata[1];
        if (wr_en[0]) store[addr[0]] <= wdata[0];
    end

    // Combinational lookup; the port registers it at the sampling edge,
    // so a same-edge write from the other port is not seen (old data, R9).
    for (genvar i = 0; i < dpm_pkg::NUM_PORTS; i++) begin : g_rd
        assign rdata[i] = store[addr[i]];
    end

endmodule

// File: rtl/dpm_port.sv
module dpm_port
    import dpm_pkg::*;
#(
    parameter int DATA_W = 72,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_sel,
    input  logic              en0,
    input  logic              en1,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    lat_state_e        state_q, state_d;
    logic              access;
    logic              rd_req;
    logic              s1_vld, s2_vld;
    logic [DATA_W-1:0] s1_data, s2_data;

    // Access qualification: both enables must be high (R2).
    assign access    = en0 & en1;
    assign rd_req    = access & ~wr;
    assign mem_we    = access & wr;
    assign mem_addr  = addr;
    assign mem_wdata = wdata;

    // Next state: reset-select while in reset, hold otherwise (R8).
    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d = pipe_sel ? ST_PIPE : ST_FLOW;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Read data stages; only the valid bits are reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
            s2_vld <= 1'b0;
        end else begin
            s1_vld <= rd_req;
            s2_vld <= s1_vld;
        end
        s1_data <= mem_rdata;
        s2_data <= s1_data;
    end

    // Outputs: pick the tap for the latency, force zero when not valid (R6).
    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state_q)
            ST_FLOW: begin
                rvalid = s1_vld;
                rdata  = s1_vld ? s1_data : '0;
            end
            ST_PIPE: begin
                rvalid = s2_vld;
                rdata  = s2_vld ? s2_data : '0;
            end
            default: begin
                rvalid = 1'b0;
                rdata  = '0;
            end
        endcase
    end

endmodule

// File: rtl/dpm_dual_top.sv
module dpm_dual_top
    import dpm_pkg::*;
#(
    parameter int DATA_W = 72,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_pipe_sel,
    input  logic              a_en0,
    input  logic              a_en1,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    input  logic              b_pipe_sel,
    input  logic              b_en0,
    input  logic              b_en1,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid
);
    logic [NUM_PORTS-1:0]             p_pipe_sel, p_en0, p_en1, p_wr, p_rvalid, m_we;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] p_addr, m_addr;
    logic [NUM_PORTS-1:0][DATA_W-1:0] p_wdata, p_rdata, m_wdata, m_rdata;

    assign p_pipe_sel = {b_pipe_sel, a_pipe_sel};
    assign p_en0      = {b_en0, a_en0};
    assign p_en1      = {b_en1, a_en1};
    assign p_wr       = {b_wr, a_wr};
    assign p_addr     = {b_addr, a_addr};
    assign p_wdata    = {b_wdata, a_wdata};

    assign a_rdata  = p_rdata[0];
    assign a_rvalid = p_rvalid[0];
    assign b_rdata  = p_rdata[1];
    assign b_rvalid = p_rvalid[1];

    // One independent port engine per side (R1, R10).
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        dpm_port #(
            .DATA_W(DATA_W),
            .ADDR_W(ADDR_W)
        ) u_port (
            .clk      (clk),
            .rst      (rst),
            .pipe_sel (p_pipe_sel[i]),
            .en0      (p_en0[i]),
            .en1      (p_en1[i]),
            .wr       (p_wr[i]),
            .addr     (p_addr[i]),
            .wdata    (p_wdata[i]),
            .mem_rdata(m_rdata[i]),
            .mem_we   (m_we[i]),
            .mem_addr (m_addr[i]),
            .mem_wdata(m_wdata[i]),
            .rdata    (p_rdata[i]),
            .rvalid   (p_rvalid[i])
        );
    end

    dpm_shared_array #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_array (
        .clk  (clk),
        .wr_en(m_we),
        .addr (m_addr),
        .wdata(m_wdata),
        .rdata(m_rdata)
    );

endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
    parameter int DATA_W = 72
) (
    input logic              clk,
    input logic              rst,
    input logic              a_pipe_sel,
    input logic              a_en0,
    input logic              a_en1,
    input logic              a_wr,
    input logic [DATA_W-1:0] a_rdata,
    input logic              a_rvalid,
    input logic              b_pipe_sel,
    input logic              b_en0,
    input logic              b_en1,
    input logic              b_wr,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_rvalid
);
    logic       a_mode_q, b_mode_q;
    logic [1:0] age_q;
    logic       a_rd1, a_rd2, b_rd1, b_rd2;

    // Latency captured independently from the select pins during reset (R8).
    always_ff @(posedge clk) begin
        if (rst) begin
            a_mode_q <= a_pipe_sel;
            b_mode_q <= b_pipe_sel;
            age_q    <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
        a_rd1 <= a_en0 & a_en1 & ~a_wr;
        a_rd2 <= a_rd1;
        b_rd1 <= b_en0 & b_en1 & ~b_wr;
        b_rd2 <= b_rd1;
    end

    // R3, R5: one-cycle valid tracking in flow mode.
    a_r3_a_flow_latency: assert property (@(posedge clk) disable iff (rst)
        (!a_mode_q && age_q >= 2'd1) |-> (a_rvalid == a_rd1));
    a_r3_b_flow_latency: assert property (@(posedge clk) disable iff (rst)
        (!b_mode_q && age_q >= 2'd1) |-> (b_rvalid == b_rd1));

    // R4, R5: two-cycle valid tracking in pipelined mode.
    a_r4_a_pipe_latency: assert property (@(posedge clk) disable iff (rst)
        (a_mode_q && age_q >= 2'd2) |-> (a_rvalid == a_rd2));
    a_r4_b_pipe_latency: assert property (@(posedge clk) disable iff (rst)
        (b_mode_q && age_q >= 2'd2) |-> (b_rvalid == b_rd2));

    // R6: bus is zero whenever it is not valid.
    a_r6_a_zero_idle: assert property (@(posedge clk) disable iff (rst)
        !a_rvalid |-> (a_rdata == '0));
    a_r6_b_zero_idle: assert property (@(posedge clk) disable iff (rst)
        !b_rvalid |-> (b_rdata == '0));

endmodule

bind dpm_dual_top dpm_checker #(.DATA_W(DATA_W)) i_dpm_checker (
    .clk       (clk),
    .rst       (rst),
    .a_pipe_sel(a_pipe_sel),
    .a_en0     (a_en0),
    .a_en1     (a_en1),
    .a_wr      (a_wr),
    .a_rdata   (a_rdata),
    .a_rvalid  (a_rvalid),
    .b_pipe_sel(b_pipe_sel),
    .b_en0     (b_en0),
    .b_en1     (b_en1),
    .b_wr      (b_wr),
    .b_rdata   (b_rdata),
    .b_rvalid  (b_rvalid)
);

// File: tb/test_dpm_dual_top.sv
module test_dpm_dual_top;

    localparam int DW = 72;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          a_pipe_sel, a_en0, a_en1, a_wr, a_rvalid;
    logic          b_pipe_sel, b_en0, b_en1, b_wr, b_rvalid;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;

    int  total = 0;
    int  bad   = 0;
    bit  a_pipe_m, b_pipe_m;

    always #10 clk = ~clk;

    dpm_dual_top #(.DATA_W(DW), .ADDR_W(AW)) i_dpm_dual_top (
        .clk(clk), .rst(rst),
        .a_pipe_sel(a_pipe_sel), .a_en0(a_en0), .a_en1(a_en1), .a_wr(a_wr),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
        .b_pipe_sel(b_pipe_sel), .b_en0(b_en0), .b_en1(b_en1), .b_wr(b_wr),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_port(int p, bit e0, bit e1, bit w, logic [AW-1:0] ad, logic [DW-1:0] d);
        if (p == 0) begin
            a_en0 = e0; a_en1 = e1; a_wr = w; a_addr = ad; a_wdata = d;
        end else begin
            b_en0 = e0; b_en1 = e1; b_wr = w; b_addr = ad; b_wdata = d;
        end
    endtask

    task automatic idle_all();
        set_port(0, 0, 0, 0, '0, '0);
        set_port(1, 0, 0, 0, '0, '0);
    endtask

    function automatic logic [DW-1:0] word(int k);
        return {8'h5A, 32'hC0DE_0000 + k, 32'h1234_0000 + k};
    endfunction

    task automatic do_reset(bit am, bit bm);
        rst = 1'b1;
        a_pipe_sel = am;
        b_pipe_sel = bm;
        idle_all();
        tick();
        tick();
        rst = 1'b0;
        a_pipe_m = am;
        b_pipe_m = bm;
    endtask

    task automatic write_port(int p, logic [AW-1:0] ad, logic [DW-1:0] d);
        set_port(p, 1, 1, 1, ad, d);
        tick();
        set_port(p, 0, 0, 0, '0, '0);
        check("R5 write yields no valid", p == 0 ? a_rvalid : b_rvalid, '0);
    endtask

    task automatic read_expect(int p, logic [AW-1:0] ad, logic [DW-1:0] exp, string tag);
        bit pm = (p == 0) ? a_pipe_m : b_pipe_m;
        set_port(p, 1, 1, 0, ad, '0);
        tick();
        set_port(p, 0, 0, 0, '0, '0);
        if (pm) begin
            check({tag, " R4 not valid after one edge"}, p == 0 ? a_rvalid : b_rvalid, '0);
            tick();
        end
        check({tag, " valid"}, p == 0 ? a_rvalid : b_rvalid, 1);
        check({tag, " data"}, p == 0 ? a_rdata : b_rdata, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        a_pipe_sel = 1'b0;
        b_pipe_sel = 1'b1;
        set_port(0, 1, 1, 0, 6'd1, '0);
        set_port(1, 1, 1, 0, 6'd1, '0);
        tick();
        tick();
        check("R6 reset a_rvalid", a_rvalid, '0);
        check("R6 reset a_rdata", a_rdata, '0);
        check("R6 reset b_rvalid", b_rvalid, '0);
        check("R6 reset b_rdata", b_rdata, '0);
        do_reset(0, 0);
    endtask

    task automatic t_cross_port();
        write_port(0, 6'd3, word(1));
        read_expect(1, 6'd3, word(1), "R1 R3 B reads A word");
        write_port(1, 6'd4, word(2));
        read_expect(0, 6'd4, word(2), "R1 R3 A reads B word");
    endtask

    task automatic t_enable_gating();
        set_port(0, 0, 1, 1, 6'd3, word(7));
        tick();
        set_port(0, 1, 0, 1, 6'd3, word(8));
        tick();
        set_port(0, 0, 0, 0, '0, '0);
        read_expect(0, 6'd3, word(1), "R2 gated write ignored");
        set_port(1, 1, 0, 0, 6'd3, '0);
        tick();
        set_port(1, 0, 0, 0, '0, '0);
        check("R5 gated read no valid", b_rvalid, '0);
        check("R6 gated read zero bus", b_rdata, '0);
    endtask

    task automatic t_write_then_read();
        set_port(0, 1, 1, 1, 6'd9, word(3));
        tick();
        set_port(0, 1, 1, 0, 6'd9, '0);
        tick();
        set_port(0, 0, 0, 0, '0, '0);
        check("R7 next-edge read valid", a_rvalid, 1);
        check("R7 next-edge read data", a_rdata, word(3));
    endtask

    task automatic t_collision();
        set_port(0, 1, 1, 1, 6'd5, word(10));
        set_port(1, 1, 1, 1, 6'd5, word(11));
        tick();
        idle_all();
        read_expect(1, 6'd5, word(10), "R9 port A wins");
        write_port(0, 6'd6, word(12));
        set_port(0, 1, 1, 1, 6'd6, word(13));
        set_port(1, 1, 1, 0, 6'd6, '0);
        tick();
        idle_all();
        check("R9 same-cycle read old valid", b_rvalid, 1);
        check("R9 same-cycle read old data", b_rdata, word(12));
        read_expect(1, 6'd6, word(13), "R9 new word after");
    endtask

    task automatic t_mixed_modes();
        do_reset(1, 0);
        write_port(0, 6'd20, word(20));
        set_port(0, 1, 1, 0, 6'd20, '0);
        set_port(1, 1, 1, 0, 6'd20, '0);
        tick();
        idle_all();
        check("R10 R3 flow B valid", b_rvalid, 1);
        check("R10 R3 flow B data", b_rdata, word(20));
        check("R10 R4 pipe A not yet", a_rvalid, '0);
        tick();
        check("R10 R4 pipe A valid", a_rvalid, 1);
        check("R10 R4 pipe A data", a_rdata, word(20));
        check("R10 R5 flow B dropped", b_rvalid, '0);
    endtask

    task automatic t_mode_locked();
        a_pipe_sel = 1'b0;
        b_pipe_sel = 1'b1;
        tick();
        read_expect(0, 6'd20, word(20), "R8 A stays pipelined");
        read_expect(1, 6'd20, word(20), "R8 B stays flow");
    endtask

    task automatic t_stream();
        for (int k = 0; k < 4; k++) write_port(0, 6'(30 + k), word(40 + k));
        for (int k = 0; k < 6; k++) begin
            if (k < 4) set_port(0, 1, 1, 0, 6'(30 + k), '0);
            else       set_port(0, 0, 0, 0, '0, '0);
            tick();
            if (k >= 1 && k <= 4) begin
                check("R4 stream valid", a_rvalid, 1);
                check("R4 stream data", a_rdata, word(40 + k - 1));
            end else begin
                check("R4 stream gap", a_rvalid, '0);
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_cross_port();
        t_enable_gating();
        t_write_then_read();
        t_collision();
        t_mixed_modes();
        t_mode_locked();
        t_stream();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule